// File: doc/BRIEF.md
# Conditional Trap and Branch Evaluator

This block is the decision stage for compare-style control instructions in a 32-bit integer pipeline. It looks at the primary opcode, the six-bit function field and the five-bit register-immediate selector of an instruction. It also takes the two source register values and the raw 16-bit immediate. From these it decides, in the same cycle, whether a conditional trap fires or a conditional branch is taken. The block is purely combinational.

A single comparison core serves all instruction groups. The groups are the register-register traps, the register-immediate traps, the sign tests of one register against zero (with optional link and "likely" forms) and the two-register equality branches. Besides the two decision flags, the block reports whether the branch writes the return register. It also reports whether the instruction in the delay slot must be squashed because a "likely" branch fell through. Target address arithmetic, delay-slot sequencing and exception entry belong to neighbouring blocks.

Top module: `cond_eval`

## Requirements
- R1: With opcode 0x00, function codes 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 raise `trap_raise` when lhs >= rhs signed, lhs >= rhs unsigned, lhs < rhs signed, lhs < rhs unsigned, lhs == rhs and lhs != rhs respectively. The other outputs stay 0.
- R2: With opcode 0x01, selector codes 0x08, 0x09, 0x0A, 0x0B, 0x0C and 0x0E raise `trap_raise` under the same six conditions, in that order. The second operand is the immediate, sign-extended to 32 bits.
- R3: For the unsigned immediate traps (0x09, 0x0B), the immediate is sign-extended first and then compared as an unsigned 32-bit value. For example, 0xFFFF is compared as 0xFFFFFFFF.
- R4: With opcode 0x01, selector 0x00 takes the branch when lhs is negative (bit 31 set). Selector 0x01 takes it when lhs is non-negative.
- R5: Selectors 0x02 and 0x03 apply the tests of 0x00 and 0x01 as "likely" branches.
- R6: Selectors 0x10 to 0x13 repeat the tests of 0x00 to 0x03 and assert `link_write` whether or not the branch is taken. No other code asserts `link_write`.
- R7: Opcode 0x04 takes the branch when lhs == rhs. Opcode 0x05 takes it when lhs != rhs.
- R8: Opcode 0x06 takes the branch when lhs <= 0 signed. Opcode 0x07 takes it when lhs > 0 signed. rhs is ignored for both.
- R9: Opcodes 0x14 to 0x17 apply the tests of 0x04 to 0x07 as "likely" branches.
- R10: Any other combination of opcode, function and selector drives all four outputs to 0. `trap_raise` and `branch_take` are never both 1.
- R11: `nullify_slot` is 1 exactly when a "likely" branch is not taken. It is never 1 together with `branch_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode field |
| func_code | input | 6 | Function field, used with opcode 0x00 |
| regimm_code | input | 5 | Register-immediate selector, used with opcode 0x01 |
| lhs_val | input | DATA_W (32) | First source register value |
| rhs_val | input | DATA_W (32) | Second source register value |
| imm_val | input | IMM_W (16) | Raw immediate, sign-extended inside |
| trap_raise | output | 1 | Conditional trap fires |
| branch_take | output | 1 | Conditional branch is taken |
| link_write | output | 1 | Branch writes the return register |
| nullify_slot | output | 1 | Delay-slot instruction must be squashed |

## Verification
The checker treats every field value as meaningful, so the only thing it takes for granted is that the inputs are settled, two-state values when the combinational assertions evaluate. The bench keeps to this by changing inputs only on the falling clock edge and reading outputs a fixed time later. Within that limit the stimulus sweeps every opcode, every function code under opcode 0x00 and every selector under opcode 0x01. Each is paired with operand sets at the sign, zero and wrap boundaries where signed and unsigned orderings disagree.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_REGIMM  = 6'h01;

  // Low three bits of the trap kinds match the trap code ordering.
  typedef enum logic [3:0] {
    CMP_GE_S  = 4'd0,
    CMP_GE_U  = 4'd1,
    CMP_LT_S  = 4'd2,
    CMP_LT_U  = 4'd3,
    CMP_EQ    = 4'd4,
    CMP_NE    = 4'd6,
    CMP_LE_S  = 4'd8,
    CMP_GT_S  = 4'd9,
    CMP_NEVER = 4'd15
  } cmp_kind_t;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TRAP   = 2'd1,
    ACT_BRANCH = 2'd2
  } act_t;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_ZERO = 2'd2
  } src_sel_t;

  typedef struct packed {
    act_t      act;
    cmp_kind_t cmp;
    src_sel_t  src;
    logic      likely;
    logic      link;
  } ctl_t;

endpackage

// File: rtl/cond_decode.sv
module cond_decode
  import cond_eval_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] func_code,
  input  logic [4:0] regimm_code,
  output ctl_t       ctl
);

  // Trap sub-codes 5 and 7 are holes in the six-condition table.
  function automatic logic trap_code_ok(input logic [2:0] c);
    return (c != 3'd5) && (c != 3'd7);
  endfunction

  logic special_trap;
  logic regimm_trap;
  logic regimm_branch;
  logic primary_branch;

  assign special_trap   = (op_code == OPC_SPECIAL) && (func_code[5:3] == 3'b110)
                          && trap_code_ok(func_code[2:0]);
  assign regimm_trap    = (op_code == OPC_REGIMM) && (regimm_code[4:3] == 2'b01)
                          && trap_code_ok(regimm_code[2:0]);
  assign regimm_branch  = (op_code == OPC_REGIMM) && (regimm_code[3:2] == 2'b00);
  assign primary_branch = (op_code[5] == 1'b0) && (op_code[3:2] == 2'b01);

  always_comb begin
    ctl        = '0;
    ctl.act    = ACT_NONE;
    ctl.cmp    = CMP_NEVER;
    ctl.src    = SRC_REG;
    if (special_trap) begin
      ctl.act = ACT_TRAP;
      ctl.cmp = cmp_kind_t'({1'b0, func_code[2:0]});
      ctl.src = SRC_REG;
    end else if (regimm_trap) begin
      ctl.act = ACT_TRAP;
      ctl.cmp = cmp_kind_t'({1'b0, regimm_code[2:0]});
      ctl.src = SRC_IMM;
    end else if (regimm_branch) begin
      ctl.act    = ACT_BRANCH;
      ctl.cmp    = regimm_code[0] ? CMP_GE_S : CMP_LT_S;
      ctl.src    = SRC_ZERO;
      ctl.likely = regimm_code[1];
      ctl.link   = regimm_code[4];
    end else if (primary_branch) begin
      ctl.act    = ACT_BRANCH;
      ctl.likely = op_code[4];
      unique case (op_code[1:0])
        2'd0:    begin ctl.cmp = CMP_EQ;   ctl.src = SRC_REG;  end
        2'd1:    begin ctl.cmp = CMP_NE;   ctl.src = SRC_REG;  end
        2'd2:    begin ctl.cmp = CMP_LE_S; ctl.src = SRC_ZERO; end
        default: begin ctl.cmp = CMP_GT_S; ctl.src = SRC_ZERO; end
      endcase
    end
  end

endmodule

// File: rtl/cond_operand.sv
module cond_operand
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  src_sel_t          src,
  input  logic [DATA_W-1:0] rhs_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int EXT_W = (DATA_W > IMM_W) ? DATA_W - IMM_W : 1;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_extend
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_trim
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_IMM:  opnd_b = imm_ext;
      SRC_ZERO: opnd_b = '0;
      default:  opnd_b = rhs_val;
    endcase
  end

endmodule

// File: rtl/cond_compare.sv
module cond_compare
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_kind_t         kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              hit
);

  function automatic logic f_less_signed(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic f_less_unsigned(input logic [DATA_W-1:0] a,
                                           input logic [DATA_W-1:0] b);
    return a < b;
  endfunction

  logic eq_w;
  logic lt_s_w;
  logic lt_u_w;

  assign eq_w   = (opnd_a == opnd_b);
  assign lt_s_w = f_less_signed(opnd_a, opnd_b);
  assign lt_u_w = f_less_unsigned(opnd_a, opnd_b);

  always_comb begin
    unique case (kind)
      CMP_GE_S: hit = ~lt_s_w;
      CMP_GE_U: hit = ~lt_u_w;
      CMP_LT_S: hit = lt_s_w;
      CMP_LT_U: hit = lt_u_w;
      CMP_EQ:   hit = eq_w;
      CMP_NE:   hit = ~eq_w;
      CMP_LE_S: hit = lt_s_w | eq_w;
      CMP_GT_S: hit = ~(lt_s_w | eq_w);
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [5:0]        op_code,
  input  logic [5:0]        func_code,
  input  logic [4:0]        regimm_code,
  input  logic [DATA_W-1:0] lhs_val,
  input  logic [DATA_W-1:0] rhs_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic              trap_raise,
  output logic              branch_take,
  output logic              link_write,
  output logic              nullify_slot
);

  ctl_t              ctl_w;
  logic [DATA_W-1:0] opnd_b_w;
  logic              cond_hit_w;
  logic              is_trap_w;
  logic              is_branch_w;

  cond_decode u_dec (
    .op_code     (op_code),
    .func_code   (func_code),
    .regimm_code (regimm_code),
    .ctl         (ctl_w)
  );

  cond_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .src     (ctl_w.src),
    .rhs_val (rhs_val),
    .imm_val (imm_val),
    .opnd_b  (opnd_b_w)
  );

  cond_compare #(.DATA_W(DATA_W)) u_cmp (
    .kind   (ctl_w.cmp),
    .opnd_a (lhs_val),
    .opnd_b (opnd_b_w),
    .hit    (cond_hit_w)
  );

  assign is_trap_w    = (ctl_w.act == ACT_TRAP);
  assign is_branch_w  = (ctl_w.act == ACT_BRANCH);

  assign trap_raise   = is_trap_w & cond_hit_w;
  assign branch_take  = is_branch_w & cond_hit_w;
  assign link_write   = is_branch_w & ctl_w.link;
  assign nullify_slot = is_branch_w & ctl_w.likely & ~cond_hit_w;

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [5:0]        op_code,
  input logic [5:0]        func_code,
  input logic [4:0]        regimm_code,
  input logic [DATA_W-1:0] lhs_val,
  input logic [DATA_W-1:0] rhs_val,
  input logic [IMM_W-1:0]  imm_val,
  input logic              trap_raise,
  input logic              branch_take,
  input logic              link_write,
  input logic              nullify_slot
);

  logic [IMM_W-1:0] imm_unused;
  assign imm_unused = imm_val;

  always_comb begin
    // R10: a trap and a taken branch never coexist
    a_r10_exclusive: assert (!(trap_raise && branch_take));
    // R11: squash only on a fall-through
    a_r11_null_not_taken: assert (!(nullify_slot && branch_take));
    // R6: link only from the register-immediate link selectors
    a_r6_link_source: assert (!link_write ||
      (op_code == 6'h01 && regimm_code[4] && regimm_code[3:2] == 2'b00));
    // R1 / R2: traps only come from the two trap code groups
    a_r1_trap_source: assert (!trap_raise ||
      (op_code == 6'h00 && func_code[5:3] == 3'b110) ||
      (op_code == 6'h01 && regimm_code[4:3] == 2'b01));
    // R7: equality branch taken only on equal registers
    a_r7_beq_equal: assert (!(branch_take && op_code[3:0] == 4'h4 &&
      op_code[5] == 1'b0 && op_code[4] == 1'b0) || (lhs_val == rhs_val));
    // R9 / R5: squash only from likely encodings
    a_r9_null_source: assert (!nullify_slot ||
      (op_code[5:4] == 2'b01 && op_code[3:2] == 2'b01) ||
      (op_code == 6'h01 && regimm_code[1] && regimm_code[3:2] == 2'b00));
  end

endmodule

bind cond_eval cond_eval_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_code      (op_code),
  .func_code    (func_code),
  .regimm_code  (regimm_code),
  .lhs_val      (lhs_val),
  .rhs_val      (rhs_val),
  .imm_val      (imm_val),
  .trap_raise   (trap_raise),
  .branch_take  (branch_take),
  .link_write   (link_write),
  .nullify_slot (nullify_slot)
);

// File: tb/sim_cond_eval.sv
`timescale 1ns/1ps
module sim_cond_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_code;
  logic [5:0]  func_code;
  logic [4:0]  regimm_code;
  logic [31:0] lhs_val;
  logic [31:0] rhs_val;
  logic [15:0] imm_val;
  logic        trap_raise, branch_take, link_write, nullify_slot;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cond_eval u0 (
    .op_code(op_code), .func_code(func_code), .regimm_code(regimm_code),
    .lhs_val(lhs_val), .rhs_val(rhs_val), .imm_val(imm_val),
    .trap_raise(trap_raise), .branch_take(branch_take),
    .link_write(link_write), .nullify_slot(nullify_slot)
  );

  // Operand sets: a, b, immediate
  function automatic logic [79:0] vec(input int i);
    case (i)
      0: return {32'h0000_0000, 32'h0000_0000, 16'h0000};
      1: return {32'h0000_0005, 32'h0000_0005, 16'h0005};
      2: return {32'h0000_0005, 32'h0000_0007, 16'h0007};
      3: return {32'h0000_0007, 32'h0000_0005, 16'hFFFF};
      4: return {32'h8000_0000, 32'h0000_0001, 16'h8000};
      5: return {32'hFFFF_FFFF, 32'h0000_0000, 16'hFFFF};
      6: return {32'h0000_0001, 32'hFFFF_FFFF, 16'h7FFF};
      7: return {32'h7FFF_FFFF, 32'h8000_0000, 16'h0001};
      8: return {32'hFFFF_8000, 32'h0000_0003, 16'h8000};
      default: return {32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF};
    endcase
  endfunction

  function automatic bit six_way(input int c, input logic [31:0] x, input logic [31:0] y);
    case (c)
      0: return $signed(x) >= $signed(y);
      1: return x >= y;
      2: return $signed(x) < $signed(y);
      3: return x < y;
      4: return x == y;
      6: return x != y;
      default: return 1'b0;
    endcase
  endfunction

  // Expected {trap, taken, link, nullify}
  function automatic logic [3:0] model(input int op, input int fn, input int rt,
                                       input logic [31:0] a, input logic [31:0] b,
                                       input logic [15:0] im);
    logic [31:0] se;
    bit t;
    se = {{16{im[15]}}, im};
    if (op == 0 && fn >= 48 && fn <= 54 && fn != 53)
      return {six_way(fn - 48, a, b), 3'b000};
    if (op == 1 && rt >= 8 && rt <= 14 && rt != 13)
      return {six_way(rt - 8, a, se), 3'b000};
    if (op == 1 && (rt <= 3 || (rt >= 16 && rt <= 19))) begin
      t = (rt % 2 == 1) ? ($signed(a) >= 0) : ($signed(a) < 0);
      return {1'b0, t, (rt >= 16), ((rt % 4) >= 2) && !t};
    end
    if ((op >= 4 && op <= 7) || (op >= 20 && op <= 23)) begin
      case (op % 4)
        0: t = (a == b);
        1: t = (a != b);
        2: t = ($signed(a) <= 0);
        default: t = ($signed(a) > 0);
      endcase
      return {1'b0, t, 1'b0, (op >= 20) && !t};
    end
    return 4'b0000;
  endfunction

  function automatic string tag(input int op, input int rt);
    if (op == 0) return "R1";
    if (op == 1 && (rt == 9 || rt == 11)) return "R3";
    if (op == 1 && rt >= 8 && rt <= 14) return "R2";
    if (op == 1 && rt >= 16 && rt <= 19) return "R6";
    if (op == 1 && (rt == 2 || rt == 3)) return "R5";
    if (op == 1 && rt <= 1) return "R4";
    if (op == 4 || op == 5) return "R7";
    if (op == 6 || op == 7) return "R8";
    if (op >= 20 && op <= 23) return "R9";
    return "R10";
  endfunction

  task automatic apply(input int op, input int fn, input int rt,
                       input logic [79:0] v, input string req);
    logic [3:0] exp, got;
    @(negedge clk);
    op_code = op[5:0]; func_code = fn[5:0]; regimm_code = rt[4:0];
    {lhs_val, rhs_val, imm_val} = v;
    #1;
    exp = model(op, fn, rt, v[79:48], v[47:16], v[15:0]);
    got = {trap_raise, branch_take, link_write, nullify_slot};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h fn=%h rt=%h a=%h b=%h imm=%h got=%b exp=%b",
               req, op[5:0], fn[5:0], rt[4:0], v[79:48], v[47:16], v[15:0], got, exp);
    end
  endtask

  initial begin
    op_code = '0; func_code = '0; regimm_code = '0;
    lhs_val = '0; rhs_val = '0; imm_val = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero fields decode to nothing (R10)
    apply(0, 0, 0, vec(0), "R10");
    for (int op = 0; op < 64; op++) begin
      for (int vi = 0; vi < 10; vi++) begin
        if (op == 0) begin
          for (int fn = 0; fn < 64; fn++) apply(op, fn, 0, vec(vi), tag(op, 0));
        end else if (op == 1) begin
          for (int rt = 0; rt < 32; rt++) apply(op, 0, rt, vec(vi), tag(op, rt));
        end else begin
          // trap-looking fields under other opcodes must do nothing
          apply(op, 6'h30, 8, vec(vi), tag(op, 8));
        end
      end
    end
    // R11: likely taken never squashes, likely not taken does
    apply(20, 0, 0, {32'h9, 32'h9, 16'h0}, "R11");
    apply(20, 0, 0, {32'h9, 32'h8, 16'h0}, "R11");
    apply(1, 0, 19, {32'h0, 32'h0, 16'h0}, "R11");
    apply(1, 0, 19, {32'h8000_0000, 32'h0, 16'h0}, "R11");
    // R8: rhs ignored for the zero compares
    apply(6, 0, 0, {32'h0, 32'hFFFF_FFFF, 16'h0}, "R8");
    apply(7, 0, 0, {32'h1, 32'h7FFF_FFFF, 16'h0}, "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got hang, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule